// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block is the digital control sequencer of a data converter. Its timing is counted in master clock cycles. An active-low convert request is synchronised and starts a conversion of fixed length. At the end of each conversion the active-low ready output falls and a placeholder result counter advances. A polarity-select input is captured when each conversion starts and is held for that conversion.

If convert is held low, conversions follow each other back to back. If ready is wired to convert, each conversion requests the next. After reset is released, and again after sleep is removed, the block waits a long fixed wake-up time before it signals that it is operational by pulling ready low. A synchronous read acknowledge returns ready high once a result has been taken.

Top module: `conv_timing_seq`

## Requirements
- R1: While `rst_n` is low, `rdy_n` is 1 and `result` is 0.
- R2: After `rst_n` rises, `rdy_n` first falls on the 1536th rising clock edge. A convert request made during this wake-up starts no conversion, so `rdy_n` stays low afterwards and `result` stays 0.
- R3: When `conv_n` falls just before edge 1 (the sampling edge), the conversion starts on edge 3, which is at most 2 cycles after sampling. `rdy_n` rises on edge 3 if it was low, and falls on edge 322. A 4-cycle low pulse is always accepted, and no request waits more than 324 cycles.
- R4: With `conv_n` held low, `rdy_n` falls every 320 cycles and stays low for exactly one cycle each time.
- R5: With `rdy_n` fed back to `conv_n`, `rdy_n` falls every 322 cycles.
- R6: If `conv_n` returns high before `rdy_n` falls, exactly one conversion is performed. `rdy_n` then stays low and `result` is unchanged until the next request or read.
- R7: `pol_mode` equals the value `pol_sel` had when `conv_n` fell. Changes to `pol_sel` during the conversion do not alter it.
- R8: `result` increases by 1 on the edge where each conversion ends (modulo 2^DATA_W).
- R9: A one-cycle `rd_ack` pulse while idle with `rdy_n` low drives `rdy_n` high on the next edge.
- R10: Within 3 edges after `sleep` rises, `rdy_n` is 1. Any conversion in progress is aborted: `rdy_n` does not fall and `result` does not change while `sleep` stays high, and convert requests are ignored.
- R11: After `sleep` falls, `rdy_n` falls on the 3083rd rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Active-low convert request, asynchronous |
| pol_sel | input | 1 | Polarity select (1 = bipolar), asynchronous |
| sleep | input | 1 | Active-high sleep request, asynchronous |
| rd_ack | input | 1 | Synchronous result-read acknowledge |
| rdy_n | output | 1 | Active-low ready strobe |
| pol_mode | output | 1 | Polarity latched for the current conversion |
| result | output | DATA_W | Placeholder conversion result counter |

## Verification
In held-low mode, the end of one conversion and the start of the next happen on the same clock edge. On that edge `rdy_n` is pulled low while the counter reloads. The bench provokes this by holding `conv_n` low across several conversions. It checks that `rdy_n` is low for exactly one cycle, that the falling edges are exactly 320 cycles apart, and that `result` advances once per fall. It then releases `conv_n` during a conversion and expects that conversion to finish with no restart after it.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_BUSY  = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_e;

  function automatic int cs_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cs_sync.sv
// Multi-stage synchroniser with per-bit reset value; STAGES must be >= 2.
module cs_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_pkg::*;
#(
  parameter int CONV_CYCLES     = 320,
  parameter int WAKE_RST_CYCLES = 1536,
  parameter int WAKE_SLP_CYCLES = 3083,
  parameter int SYNC_STAGES     = 2,
  parameter int DATA_W          = 16
) (
  input  logic              clk,
  input  logic              rst_n,     // already synchronised release
  input  logic              conv_s,
  input  logic              pol_s,
  input  logic              sleep_s,
  input  logic              rd_ack,
  output logic              rdy_n,
  output logic              pol_mode,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = $clog2(cs_max3(CONV_CYCLES, WAKE_RST_CYCLES, WAKE_SLP_CYCLES) + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  // A start from idle credits the synchroniser cycles already spent, so
  // ready fed back to convert costs exactly two extra cycles per period.
  localparam logic [CNT_W-1:0] IDLE_START = CNT_W'(SYNC_STAGES - 1);
  // Wake-up counts absorb the input / reset synchroniser latency.
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(WAKE_RST_CYCLES - SYNC_STAGES - 1);
  localparam logic [CNT_W-1:0] SLP_LAST = CNT_W'(WAKE_SLP_CYCLES - SYNC_STAGES - 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rdy_q, rdy_d;
  logic              pol_q, pol_d;
  logic              slp_q, slp_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              res_en;
  logic [CNT_W-1:0]  wake_last;

  assign wake_last = slp_q ? SLP_LAST : RST_LAST;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rdy_d  = rdy_q;
    pol_d  = pol_q;
    slp_d  = slp_q;
    res_en = 1'b0;
    unique case (st_q)
      ST_WAKE: begin
        if (sleep_s) begin
          st_d = ST_SLEEP; cnt_d = '0; rdy_d = 1'b1;
        end else if (cnt_q == wake_last) begin
          st_d = ST_IDLE; cnt_d = '0; rdy_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (sleep_s) begin
          st_d = ST_SLEEP; rdy_d = 1'b1;
        end else if (!conv_s) begin
          st_d = ST_BUSY; cnt_d = IDLE_START; rdy_d = 1'b1; pol_d = pol_s;
        end else if (rd_ack) begin
          rdy_d = 1'b1;
        end
      end
      ST_BUSY: begin
        if (sleep_s) begin
          st_d = ST_SLEEP; cnt_d = '0; rdy_d = 1'b1;
        end else if (cnt_q == CONV_LAST) begin
          rdy_d  = 1'b0;
          res_en = 1'b1;
          cnt_d  = '0;
          if (!conv_s) pol_d = pol_s;   // back-to-back restart this edge
          else         st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
          rdy_d = 1'b1;
        end
      end
      ST_SLEEP: begin
        rdy_d = 1'b1;
        if (!sleep_s) begin
          st_d = ST_WAKE; cnt_d = CNT_W'(1); slp_d = 1'b1;
        end
      end
      default: st_d = ST_WAKE;
    endcase
    res_d = res_en ? res_q + 1'b1 : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAKE;
      cnt_q <= '0;
      rdy_q <= 1'b1;
      pol_q <= 1'b0;
      slp_q <= 1'b0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      pol_q <= pol_d;
      slp_q <= slp_d;
      res_q <= res_d;
    end
  end

  assign rdy_n    = rdy_q;
  assign pol_mode = pol_q;
  assign result   = res_q;

  // R3: a start from idle needs a synchronised low request one cycle earlier
  p_start_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && $past(st_q) == ST_IDLE) |-> !$past(conv_s));

  // R4: conversion counter never passes its terminal value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> (cnt_q <= CONV_LAST));

  // R7: latched polarity holds through a conversion
  p_pol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && cnt_q != CONV_LAST) |=> $stable(pol_q));

  // R8: result only moves together with a ready fall
  p_res_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> $fell(rdy_q));

  // R10: no ready strobe while asleep
  p_quiet_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP) |-> rdy_q);

  // R2: ready only falls at the end of a conversion or wake-up
  p_rdy_fall_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> ($past(st_q) == ST_WAKE ||
                      ($past(st_q) == ST_BUSY && $past(cnt_q) == CONV_LAST)));
endmodule

// File: rtl/conv_timing_seq.sv
module conv_timing_seq
  import cs_pkg::*;
#(
  parameter int CONV_CYCLES     = 320,
  parameter int WAKE_RST_CYCLES = 1536,
  parameter int WAKE_SLP_CYCLES = 3083,
  parameter int SYNC_STAGES     = 2,
  parameter int DATA_W          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_n,
  input  logic              pol_sel,
  input  logic              sleep,
  input  logic              rd_ack,
  output logic              rdy_n,
  output logic              pol_mode,
  output logic [DATA_W-1:0] result
);
  localparam int IN_W = 3;
  localparam logic [IN_W-1:0] IN_RST = 3'b001;   // {sleep, pol, conv_n}

  logic            rst_int;
  logic [IN_W-1:0] raw_in, syn_in;

  cs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int)
  );

  assign raw_in = {sleep, pol_sel, conv_n};

  cs_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  cs_seq_fsm #(
    .CONV_CYCLES(CONV_CYCLES), .WAKE_RST_CYCLES(WAKE_RST_CYCLES),
    .WAKE_SLP_CYCLES(WAKE_SLP_CYCLES), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int),
    .conv_s(syn_in[0]), .pol_s(syn_in[1]), .sleep_s(syn_in[2]),
    .rd_ack(rd_ack),
    .rdy_n(rdy_n), .pol_mode(pol_mode), .result(result)
  );
endmodule

// File: tb/conv_timing_seq_tb.sv
module conv_timing_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, conv_drv, fb_mode, pol_sel, sleep, rd_ack;
  logic conv_n, rdy_n, pol_mode;
  logic [DW-1:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign conv_n = fb_mode ? rdy_n : conv_drv;

  conv_timing_seq #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .pol_sel(pol_sel),
    .sleep(sleep), .rd_ack(rd_ack), .rdy_n(rdy_n), .pol_mode(pol_mode),
    .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; conv_drv = 1; fb_mode = 0; pol_sel = 0; sleep = 0; rd_ack = 0;
    edges(3);
    chk(rdy_n == 1, "R1 rdy_n in reset", rdy_n, 1);
    chk(result == 0, "R1 result in reset", result, 0);
    @(negedge clk) rst_n = 1;
    edges(100);                              // edge 100
    @(negedge clk) conv_drv = 0;
    edges(10);                               // edge 110
    @(negedge clk) conv_drv = 1;
    edges(1424);                             // edge 1534
    edges(1);                                // edge 1535
    chk(rdy_n == 1, "R2 rdy_n before wake end", rdy_n, 1);
    edges(1);                                // edge 1536
    chk(rdy_n == 0, "R2 rdy_n at wake end", rdy_n, 0);
    edges(400);
    chk(rdy_n == 0 && result == 0, "R2 request during wake ignored", result, 0);
  endtask

  // conv_n pulse of 4 cycles; pol changes mid conversion
  task automatic t_single(input bit p, input int exp_res, input bit was_low);
    @(negedge clk) begin conv_drv = 0; pol_sel = p; end
    edges(2);
    if (was_low) chk(rdy_n == 0, "R3 rdy_n before start", rdy_n, 0);
    edges(1);                                // edge 3
    chk(rdy_n == 1, "R3 rdy_n high at start", rdy_n, 1);
    edges(1);                                // edge 4
    @(negedge clk) conv_drv = 1;
    edges(6);                                // edge 10
    @(negedge clk) pol_sel = ~p;
    edges(311);                              // edge 321
    chk(rdy_n == 1, "R3 rdy_n before end", rdy_n, 1);
    edges(1);                                // edge 322
    chk(rdy_n == 0, "R3 rdy_n falls at edge 322", rdy_n, 0);
    chk(pol_mode == p, "R7 polarity latched at request", pol_mode, p);
    chk(result == DW'(exp_res), "R8 result step", result, exp_res);
    edges(400);
    chk(rdy_n == 0 && result == DW'(exp_res), "R6 single conversion only", result, exp_res);
    chk(pol_mode == p, "R7 later pol change ignored", pol_mode, p);
  endtask

  task automatic t_read();
    @(negedge clk) rd_ack = 1;
    @(negedge clk) rd_ack = 0;
    #1;
    chk(rdy_n == 1, "R9 read returns ready high", rdy_n, 1);
  endtask

  task automatic t_continuous(input int base);
    @(negedge clk) begin conv_drv = 0; pol_sel = 1; end
    edges(322);
    chk(rdy_n == 0, "R4 first fall", rdy_n, 0);
    chk(result == DW'(base + 1), "R8 count after first", result, base + 1);
    edges(1);                                // edge 323
    chk(rdy_n == 1, "R4 one-cycle low", rdy_n, 1);
    edges(318);                              // edge 641
    chk(rdy_n == 1, "R4 before second fall", rdy_n, 1);
    edges(1);                                // edge 642
    chk(rdy_n == 0, "R4 period 320", rdy_n, 0);
    chk(result == DW'(base + 2), "R8 count after second", result, base + 2);
    @(negedge clk) conv_drv = 1;
    edges(320);                              // edge 962
    chk(rdy_n == 0, "R4 in-flight conversion completes", rdy_n, 0);
    edges(330);
    chk(rdy_n == 0 && result == DW'(base + 3), "R6 no restart after release", result, base + 3);
  endtask

  task automatic t_feedback(input int base);
    @(negedge clk) fb_mode = 1;
    edges(321);
    chk(rdy_n == 1, "R5 before first fall", rdy_n, 1);
    edges(1);                                // edge 322
    chk(rdy_n == 0, "R5 first fall", rdy_n, 0);
    edges(321);                              // edge 643
    chk(rdy_n == 1, "R5 before second fall", rdy_n, 1);
    edges(1);                                // edge 644
    chk(rdy_n == 0, "R5 period 322", rdy_n, 0);
    chk(result == DW'(base + 2), "R8 feedback count", result, base + 2);
    @(negedge clk) begin fb_mode = 0; conv_drv = 1; end
    edges(5);
  endtask

  task automatic t_sleep();
    int res0;
    res0 = int'(result);
    @(negedge clk) conv_drv = 0;
    edges(4);
    @(negedge clk) conv_drv = 1;
    edges(96);
    @(negedge clk) sleep = 1;
    edges(3);
    chk(rdy_n == 1, "R10 ready high in sleep", rdy_n, 1);
    edges(50);
    @(negedge clk) conv_drv = 0;
    edges(8);
    @(negedge clk) conv_drv = 1;
    edges(400);
    chk(rdy_n == 1, "R10 conversion aborted", rdy_n, 1);
    chk(result == DW'(res0), "R10 result unchanged", result, res0);
    @(negedge clk) sleep = 0;
    edges(3082);
    chk(rdy_n == 1, "R11 before wake end", rdy_n, 1);
    edges(1);
    chk(rdy_n == 0, "R11 ready falls at 3083", rdy_n, 0);
    chk(result == DW'(res0), "R11 result kept", result, res0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_single(1'b1, 1, 1'b1);
    t_single(1'b0, 2, 1'b1);
    t_read();
    t_single(1'b1, 3, 1'b0);
    t_continuous(3);
    t_feedback(6);
    t_sleep();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule